// File: doc/BRIEF.md
# Single-Cycle Six-Instruction Processor Core

This block is a 32-bit processor core that retires one instruction on every rising clock edge. In one cycle it sends the program counter to an instruction memory and decodes the returned word. It reads two operands from a 32-entry register file and forms a result in an ALU, or forms a data-memory address there. It then writes the result, or the loaded word, back to the register file. Branches are resolved in the same cycle. A dedicated incrementer and a separate target adder choose the next program counter.

Both memories sit outside the core. The instruction port is a combinational read: an address goes out and the word comes back in the same cycle. The data port presents an address, write data and a write strobe, and accepts combinational read data. The surrounding memory is expected to index 256 words with address bits [9:2] and to write on the rising edge. The register-file write port is also brought out, so the retirement of every register-writing instruction can be observed from outside.

The decoder sorts each fetched word into one of seven instruction kinds: add, subtract, or-immediate, load, store, branch-if-equal, and a no-operation kind for every other encoding. A second process maps each kind to the control bundle that steers the datapath.

Top module: `sc_core`

## Requirements
- R1: While `rst` is high at a rising edge, the program counter becomes 0. While `rst` is high, `dmem_we` and `wb_en` stay low. All 31 writable registers read as 0 after reset.
- R2: op 0x00 with funct 0x21 writes R[rs]+R[rt] to R[rd]. op 0x00 with funct 0x23 writes R[rs]-R[rt] to R[rd]. Both wrap modulo 2^32 and never trap. Fields are op[31:26], rs[25:21], rt[20:16], rd[15:11], funct[5:0].
- R3: op 0x0D writes R[rs] OR {16'h0, imm[15:0]} to R[rt].
- R4: op 0x23 drives `dmem_addr` = R[rs]+sign-extended imm and writes `dmem_rdata` to R[rt].
- R5: op 0x2B raises `dmem_we`, drives `dmem_addr` = R[rs]+sign-extended imm and `dmem_wdata` = R[rt], and writes no register.
- R6: op 0x04 sets the next PC to PC+4+(sign-extended imm << 2) when R[rs]==R[rt], and to PC+4 otherwise.
- R7: Every instruction other than op 0x04 sets the next PC to PC+4.
- R8: Register 0 always reads as 0. An instruction that names register 0 as destination leaves `wb_en` low and changes nothing.
- R9: A register write takes effect at the rising edge that retires the instruction. The following instruction reads the new value.
- R10: Any other encoding, including op 0x00 with a funct other than 0x21 or 0x23, writes no register and no memory, and advances the PC by 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous reset, active high |
| imem_addr | output | 32 | Program counter, byte address of the instruction |
| imem_data | input | 32 | Instruction word returned for `imem_addr` |
| dmem_addr | output | 32 | Data-memory byte address (ALU result) |
| dmem_wdata | output | 32 | Store data |
| dmem_we | output | 1 | Store strobe, sampled by the memory at the rising edge |
| dmem_rdata | input | 32 | Combinational load data for `dmem_addr` |
| wb_en | output | 1 | Register write this cycle |
| wb_reg | output | 5 | Destination register of the write |
| wb_data | output | 32 | Value written |

## Verification
Within one cycle, a register is read by the instruction being executed while the same register is written back by that instruction. A chain such as an add whose destination is also its source, followed by a reader of that destination, provokes the write-port/read-port overlap. The bench judges it by comparing every written value with a model that updates its register array only after the instruction completes. A branch and a store can also meet the register path in one cycle. Random programs place loads directly after stores to the same address, and forward and backward branches directly after writes to the compared registers. An instruction-level model checks each retirement, each store and the program counter.

// File: rtl/sc_core_pkg.sv
package sc_core_pkg;

    localparam int XLEN    = 32;
    localparam int NREGS   = 32;
    localparam int RIDX_W  = $clog2(NREGS);
    localparam int IMM_W   = 16;
    localparam int OPC_W   = 6;

    localparam logic [OPC_W-1:0] OPC_REG   = 6'h00;
    localparam logic [OPC_W-1:0] OPC_ORI   = 6'h0D;
    localparam logic [OPC_W-1:0] OPC_LOAD  = 6'h23;
    localparam logic [OPC_W-1:0] OPC_STORE = 6'h2B;
    localparam logic [OPC_W-1:0] OPC_BEQ   = 6'h04;
    localparam logic [OPC_W-1:0] FN_ADD_U  = 6'h21;
    localparam logic [OPC_W-1:0] FN_SUB_U  = 6'h23;

    typedef enum logic [2:0] {
        KIND_ADD,
        KIND_SUB,
        KIND_ORIMM,
        KIND_LOAD,
        KIND_STORE,
        KIND_BRANCH,
        KIND_NONE
    } ikind_e;

    typedef enum logic [1:0] {
        ALU_PLUS,
        ALU_MINUS,
        ALU_LOR
    } aluop_e;

    typedef struct packed {
        logic   reg_write;
        logic   dest_rd;
        logic   src_imm;
        logic   imm_zero;
        logic   mem_write;
        logic   load_sel;
        logic   is_branch;
        aluop_e alu_op;
    } ctrl_t;

endpackage

// File: rtl/sc_decode.sv
module sc_decode
    import sc_core_pkg::*;
(
    input  logic [OPC_W-1:0] opcode,
    input  logic [OPC_W-1:0] funct,
    output ikind_e           kind,
    output ctrl_t            ctrl
);

    // instruction classification
    always_comb begin
        kind = KIND_NONE;
        unique case (opcode)
            OPC_REG: begin
                unique case (funct)
                    FN_ADD_U: kind = KIND_ADD;
                    FN_SUB_U: kind = KIND_SUB;
                    default:  kind = KIND_NONE;
                endcase
            end
            OPC_ORI:   kind = KIND_ORIMM;
            OPC_LOAD:  kind = KIND_LOAD;
            OPC_STORE: kind = KIND_STORE;
            OPC_BEQ:   kind = KIND_BRANCH;
            default:   kind = KIND_NONE;
        endcase
    end

    // control bundle per kind
    always_comb begin
        ctrl        = '0;
        ctrl.alu_op = ALU_PLUS;
        unique case (kind)
            KIND_ADD: begin
                ctrl.reg_write = 1'b1;
                ctrl.dest_rd   = 1'b1;
                ctrl.alu_op    = ALU_PLUS;
            end
            KIND_SUB: begin
                ctrl.reg_write = 1'b1;
                ctrl.dest_rd   = 1'b1;
                ctrl.alu_op    = ALU_MINUS;
            end
            KIND_ORIMM: begin
                ctrl.reg_write = 1'b1;
                ctrl.src_imm   = 1'b1;
                ctrl.imm_zero  = 1'b1;
                ctrl.alu_op    = ALU_LOR;
            end
            KIND_LOAD: begin
                ctrl.reg_write = 1'b1;
                ctrl.src_imm   = 1'b1;
                ctrl.load_sel  = 1'b1;
                ctrl.alu_op    = ALU_PLUS;
            end
            KIND_STORE: begin
                ctrl.src_imm   = 1'b1;
                ctrl.mem_write = 1'b1;
                ctrl.alu_op    = ALU_PLUS;
            end
            KIND_BRANCH: begin
                ctrl.is_branch = 1'b1;
                ctrl.alu_op    = ALU_MINUS;
            end
            KIND_NONE: begin
                ctrl.alu_op    = ALU_PLUS;
            end
            default: ctrl.alu_op = ALU_PLUS;
        endcase
    end

endmodule

// File: rtl/sc_regfile.sv
module sc_regfile
    import sc_core_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [RIDX_W-1:0] rd_a_idx,
    input  logic [RIDX_W-1:0] rd_b_idx,
    output logic [XLEN-1:0]   rd_a_val,
    output logic [XLEN-1:0]   rd_b_val,
    input  logic              wr_en,
    input  logic [RIDX_W-1:0] wr_idx,
    input  logic [XLEN-1:0]   wr_val
);

    logic [XLEN-1:0] cells [1:NREGS-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 1; i < NREGS; i++) begin
                cells[i] <= '0;
            end
        end else if (wr_en && (wr_idx != '0)) begin
            cells[wr_idx] <= wr_val;
        end
    end

    always_comb begin
        rd_a_val = (rd_a_idx == '0) ? '0 : cells[rd_a_idx];
        rd_b_val = (rd_b_idx == '0) ? '0 : cells[rd_b_idx];
    end

endmodule

// File: rtl/sc_alu.sv
module sc_alu
    import sc_core_pkg::*;
(
    input  logic [XLEN-1:0] opnd_a,
    input  logic [XLEN-1:0] opnd_b,
    input  aluop_e          op,
    output logic [XLEN-1:0] result,
    output logic            is_zero
);

    always_comb begin
        unique case (op)
            ALU_PLUS:  result = opnd_a + opnd_b;
            ALU_MINUS: result = opnd_a - opnd_b;
            ALU_LOR:   result = opnd_a | opnd_b;
            default:   result = opnd_a + opnd_b;
        endcase
        is_zero = (result == '0);
    end

endmodule

// File: rtl/sc_pcunit.sv
module sc_pcunit
    import sc_core_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            take,
    input  logic [XLEN-1:0] offset_sx,
    output logic [XLEN-1:0] pc
);

    logic [XLEN-1:0] pc_seq;
    logic [XLEN-1:0] pc_tgt;

    always_comb begin
        pc_seq = pc + XLEN'(4);
        pc_tgt = pc_seq + {offset_sx[XLEN-3:0], 2'b00};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pc <= '0;
        end else begin
            pc <= take ? pc_tgt : pc_seq;
        end
    end

endmodule

// File: rtl/sc_core.sv
module sc_core
    import sc_core_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    output logic [XLEN-1:0]   imem_addr,
    input  logic [XLEN-1:0]   imem_data,
    output logic [XLEN-1:0]   dmem_addr,
    output logic [XLEN-1:0]   dmem_wdata,
    output logic              dmem_we,
    input  logic [XLEN-1:0]   dmem_rdata,
    output logic              wb_en,
    output logic [RIDX_W-1:0] wb_reg,
    output logic [XLEN-1:0]   wb_data
);

    logic [OPC_W-1:0]  f_op;
    logic [OPC_W-1:0]  f_fn;
    logic [RIDX_W-1:0] f_rs;
    logic [RIDX_W-1:0] f_rt;
    logic [RIDX_W-1:0] f_rd;
    logic [IMM_W-1:0]  f_imm;

    ikind_e            kind;
    ctrl_t             ctrl;
    logic [XLEN-1:0]   rs_val;
    logic [XLEN-1:0]   rt_val;
    logic [XLEN-1:0]   imm_sx;
    logic [XLEN-1:0]   imm_ext;
    logic [XLEN-1:0]   alu_b;
    logic [XLEN-1:0]   alu_res;
    logic              alu_zero;
    logic [RIDX_W-1:0] dest;
    logic              take;
    logic [XLEN-1:0]   pc;

    assign f_op  = imem_data[31:26];
    assign f_rs  = imem_data[25:21];
    assign f_rt  = imem_data[20:16];
    assign f_rd  = imem_data[15:11];
    assign f_fn  = imem_data[5:0];
    assign f_imm = imem_data[IMM_W-1:0];

    sc_decode u_dec (
        .opcode (f_op),
        .funct  (f_fn),
        .kind   (kind),
        .ctrl   (ctrl)
    );

    sc_regfile u_rf (
        .clk      (clk),
        .rst      (rst),
        .rd_a_idx (f_rs),
        .rd_b_idx (f_rt),
        .rd_a_val (rs_val),
        .rd_b_val (rt_val),
        .wr_en    (wb_en),
        .wr_idx   (wb_reg),
        .wr_val   (wb_data)
    );

    always_comb begin
        imm_sx  = {{(XLEN-IMM_W){f_imm[IMM_W-1]}}, f_imm};
        imm_ext = ctrl.imm_zero ? {{(XLEN-IMM_W){1'b0}}, f_imm} : imm_sx;
        alu_b   = ctrl.src_imm ? imm_ext : rt_val;
        dest    = ctrl.dest_rd ? f_rd : f_rt;
    end

    sc_alu u_alu (
        .opnd_a  (rs_val),
        .opnd_b  (alu_b),
        .op      (ctrl.alu_op),
        .result  (alu_res),
        .is_zero (alu_zero)
    );

    assign take = ctrl.is_branch && alu_zero && (kind == KIND_BRANCH);

    sc_pcunit u_pc (
        .clk       (clk),
        .rst       (rst),
        .take      (take),
        .offset_sx (imm_sx),
        .pc        (pc)
    );

    always_comb begin
        imem_addr  = pc;
        dmem_addr  = alu_res;
        dmem_wdata = rt_val;
        dmem_we    = ctrl.mem_write && !rst;
        wb_reg     = dest;
        wb_en      = ctrl.reg_write && (dest != '0) && !rst;
        wb_data    = ctrl.load_sel ? dmem_rdata : alu_res;
    end

endmodule

// File: rtl/sc_core_chk.sv
module sc_core_chk
    import sc_core_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic [XLEN-1:0]   imem_addr,
    input logic [OPC_W-1:0]  op,
    input logic [IMM_W-1:0]  imm,
    input logic              dmem_we,
    input logic              wb_en,
    input logic [RIDX_W-1:0] wb_reg
);

    logic known_op;
    assign known_op = (op == OPC_REG) || (op == OPC_ORI) || (op == OPC_LOAD) ||
                      (op == OPC_STORE) || (op == OPC_BEQ);

    // R1
    reset_pc_chk: assert property (@(posedge clk) rst |=> (imem_addr == '0));

    // R1
    reset_quiet_chk: assert property (@(posedge clk) rst |-> (!dmem_we && !wb_en));

    // R7
    seq_pc_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(!rst) && ($past(op) != OPC_BEQ)) |-> (imem_addr == $past(imem_addr) + 32'd4));

    // R6
    branch_pc_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(!rst) && ($past(op) == OPC_BEQ)) |->
        ((imem_addr == $past(imem_addr) + 32'd4) ||
         (imem_addr == $past(imem_addr) + 32'd4 +
                       {{(XLEN-IMM_W-2){$past(imm[IMM_W-1])}}, $past(imm), 2'b00})));

    // R8
    zero_dest_chk: assert property (@(posedge clk) disable iff (rst)
        wb_en |-> (wb_reg != '0));

    // R5
    store_nowb_chk: assert property (@(posedge clk) disable iff (rst)
        dmem_we |-> !wb_en);

    // R10
    unknown_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !known_op |-> (!wb_en && !dmem_we));

endmodule

bind sc_core sc_core_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .imem_addr (imem_addr),
    .op        (imem_data[31:26]),
    .imm       (imem_data[15:0]),
    .dmem_we   (dmem_we),
    .wb_en     (wb_en),
    .wb_reg    (wb_reg)
);

// File: tb/sc_core_test.sv
`timescale 1ns/1ps
module sc_core_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] imem_addr, imem_data;
    logic [31:0] dmem_addr, dmem_wdata, dmem_rdata;
    logic        dmem_we, wb_en;
    logic [4:0]  wb_reg;
    logic [31:0] wb_data;

    always #10 clk = ~clk;

    logic [31:0] imem [64];
    logic [31:0] dmem [256];
    logic [31:0] mmem [256];
    logic [31:0] mreg [32];
    logic [31:0] mpc;
    int          checks = 0;
    int          errors = 0;
    bit          prev_branch;
    bit          first_step;
    int          prev_dest;

    assign imem_data  = imem[imem_addr[7:2]];
    assign dmem_rdata = dmem[dmem_addr[9:2]];

    always @(posedge clk) if (dmem_we) dmem[dmem_addr[9:2]] <= dmem_wdata;

    sc_core uut (
        .clk(clk), .rst(rst),
        .imem_addr(imem_addr), .imem_data(imem_data),
        .dmem_addr(dmem_addr), .dmem_wdata(dmem_wdata), .dmem_we(dmem_we),
        .dmem_rdata(dmem_rdata),
        .wb_en(wb_en), .wb_reg(wb_reg), .wb_data(wb_data)
    );

    task automatic check32(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h at pc %h", tag, act, exp, mpc);
        end
    endtask

    function automatic logic [31:0] enc_r(int rs, int rt, int rd, logic [5:0] fn);
        return {6'h00, 5'(rs), 5'(rt), 5'(rd), 5'd0, fn};
    endfunction

    function automatic logic [31:0] enc_i(logic [5:0] op, int rs, int rt, logic [15:0] imm);
        return {op, 5'(rs), 5'(rt), imm};
    endfunction

    function automatic logic [31:0] rand_instr();
        int k  = $urandom % 8;
        int rs = $urandom % 8;
        int rt = $urandom % 8;
        int rd = $urandom % 8;
        int off;
        case (k)
            0: return enc_r(rs, rt, rd, 6'h21);
            1: return enc_r(rs, rt, rd, 6'h23);
            2: return enc_i(6'h0D, rs, rt, 16'($urandom));
            3: return enc_i(6'h23, rs, rt, 16'($urandom % 64) - 16'd32);
            4: return enc_i(6'h2B, rs, rt, 16'($urandom % 64) - 16'd32);
            5: begin
                off = int'($urandom % 9) - 4;
                if (off == -1) off = 2;
                return enc_i(6'h04, rs, ($urandom % 2 == 0) ? rs : rt, 16'(off));
            end
            6: return ($urandom % 2 == 0) ? enc_r(rs, rt, rd, 6'h20) : {6'h3F, 26'($urandom)};
            default: return enc_i(6'h0D, rs, rt, 16'($urandom));
        endcase
    endfunction

    // reset the core and the model; checks R1
    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        for (int i = 0; i < 256; i++) begin
            dmem[i] = $urandom;
            mmem[i] = dmem[i];
        end
        for (int i = 0; i < 32; i++) mreg[i] = 32'd0;
        mpc = 32'd0;
        prev_branch = 1'b0;
        first_step = 1'b1;
        prev_dest = 0;
        @(negedge clk);
        check32("R1 pc", imem_addr, 32'd0);
        check32("R1 we", {31'd0, dmem_we}, 32'd0);
        check32("R1 wb", {31'd0, wb_en}, 32'd0);
        rst = 1'b0;
    endtask

    task automatic step_check();
        logic [31:0] ins, a, b, sx, zx, e_data, e_addr, nxt;
        logic [5:0]  op, fn;
        int          rs, rt, rd, e_reg;
        bit          e_we, e_mwe, is_ld, is_br;
        string       tag, ptag;
        ins = imem[mpc[7:2]];
        op = ins[31:26]; fn = ins[5:0];
        rs = ins[25:21]; rt = ins[20:16]; rd = ins[15:11];
        a = (rs == 0) ? 32'd0 : mreg[rs];
        b = (rt == 0) ? 32'd0 : mreg[rt];
        sx = {{16{ins[15]}}, ins[15:0]};
        zx = {16'd0, ins[15:0]};
        e_we = 0; e_mwe = 0; is_ld = 0; is_br = 0;
        e_reg = 0; e_data = 0; e_addr = 0; nxt = mpc + 32'd4;
        tag = "R10";
        if (op == 6'h00 && fn == 6'h21) begin
            e_we = 1; e_reg = rd; e_data = a + b; tag = "R2";
        end else if (op == 6'h00 && fn == 6'h23) begin
            e_we = 1; e_reg = rd; e_data = a - b; tag = "R2";
        end else if (op == 6'h0D) begin
            e_we = 1; e_reg = rt; e_data = a | zx; tag = "R3";
        end else if (op == 6'h23) begin
            e_we = 1; e_reg = rt; e_addr = a + sx; is_ld = 1;
            e_data = mmem[e_addr[9:2]]; tag = "R4";
        end else if (op == 6'h2B) begin
            e_mwe = 1; e_addr = a + sx; tag = "R5";
        end else if (op == 6'h04) begin
            is_br = 1; tag = "R6";
            if (a == b) nxt = mpc + 32'd4 + {sx[29:0], 2'b00};
        end
        if (e_we && e_reg == 0) begin
            e_we = 0; tag = "R8";
        end
        if (e_we && prev_dest != 0 && (rs == prev_dest || rt == prev_dest)) tag = "R9";
        ptag = first_step ? "R1 pc" : (prev_branch ? "R6 pc" : "R7 pc");
        check32(ptag, imem_addr, mpc);
        check32({tag, " wb_en"}, {31'd0, wb_en}, {31'd0, e_we});
        if (e_we) begin
            check32({tag, " wb_reg"}, {27'd0, wb_reg}, 32'(e_reg));
            check32({tag, " wb_data"}, wb_data, e_data);
        end
        check32({tag, " dmem_we"}, {31'd0, dmem_we}, {31'd0, e_mwe});
        if (e_mwe || is_ld) check32({tag, " dmem_addr"}, dmem_addr, e_addr);
        if (e_mwe) check32({tag, " dmem_wdata"}, dmem_wdata, b);
        if (e_we) mreg[e_reg] = e_data;
        if (e_mwe) mmem[e_addr[9:2]] = b;
        prev_dest = e_we ? e_reg : 0;
        prev_branch = is_br;
        first_step = 1'b0;
        mpc = nxt;
    endtask

    task automatic run_cycles(int n);
        for (int c = 0; c < n; c++) begin
            #1;
            step_check();
            @(negedge clk);
        end
    endtask

    task automatic compare_memory();
        int mism = 0;
        for (int i = 0; i < 256; i++) if (dmem[i] !== mmem[i]) mism++;
        check32("R5 memory image", 32'(mism), 32'd0);
    endtask

    initial begin
        #(64'd200000 * 20);
        checks++;
        errors++;
        $display("FAIL watchdog: actual expired expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd20241029));
        for (int i = 0; i < 64; i++) imem[i] = 32'd0;
        // directed program
        imem[0]  = enc_i(6'h0D, 0, 1, 16'hFFFF);      // R3 zero extension
        imem[1]  = enc_r(1, 1, 2, 6'h21);             // R9 reads r1 just written
        imem[2]  = enc_r(0, 1, 3, 6'h23);             // R2 wrap below zero
        imem[3]  = enc_i(6'h0D, 1, 0, 16'h0005);      // R8 write to r0
        imem[4]  = enc_r(0, 3, 4, 6'h21);             // R8 r0 reads zero
        imem[5]  = enc_i(6'h2B, 1, 3, 16'hFFFC);      // R5 negative offset
        imem[6]  = enc_i(6'h23, 1, 5, 16'hFFFC);      // R4 load back
        imem[7]  = enc_i(6'h04, 5, 3, 16'h0001);      // R6 taken
        imem[8]  = enc_i(6'h0D, 0, 6, 16'h1234);      // skipped
        imem[9]  = enc_i(6'h04, 1, 2, 16'h0005);      // R6 not taken
        imem[10] = enc_r(1, 1, 3, 6'h20);             // R10 unsupported funct
        imem[11] = 32'hFC00_0000;                     // R10 unknown op
        imem[12] = enc_r(0, 0, 7, 6'h23);
        imem[13] = enc_r(3, 3, 8, 6'h21);             // R2 overflow wraps
        imem[14] = enc_i(6'h04, 0, 0, 16'hFFF1);      // R6 backward to 0
        do_reset();
        run_cycles(40);
        compare_memory();
        for (int p = 0; p < 24; p++) begin
            for (int i = 0; i < 64; i++) imem[i] = rand_instr();
            do_reset();
            run_cycles(120);
            compare_memory();
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule